// File: doc/BRIEF.md
# Round-Robin Page Translation Cache

This block is a small fully associative cache of address translations. It maps a 20-bit linear page number to a 20-bit physical frame number. A requester presents a page number on the lookup port. In the same cycle the block reports whether a valid entry holds that page and, if one does, returns its frame. After a page walk resolves a miss, the walker writes the new pair through the fill port. The entry that receives the pair is picked by a rotating pointer.

When the translation base changes, the controller pulses a flush input, and every cached pair is discarded on the next clock edge. The cache holds a parameterized number of entries (four by default). Each entry has a valid flag, a page key and a frame. Duplicate keys are not filtered, so a fill should only follow a miss.

Top module: `xlat_cache`

## Requirements
- R1: After reset, every lookup misses (hit low, frame output zero), including a lookup of page 0, whose stored keys are all zero.
- R2: A fill writes its page and frame into the entry under the replacement pointer and marks that entry valid. From the following cycle, a lookup of that page hits and returns that frame.
- R3: The replacement pointer starts at entry 0 and moves to the next entry after every fill, whatever the state of the entry it wrote.
- R4: The pointer wraps from the last entry (entry 3 by default) back to entry 0. The fifth fill therefore overwrites the first one, and the page evicted by it misses from then on.
- R5: A lookup is combinational. Hit and frame follow the page input within the same cycle, and the frame output is zero whenever hit is low.
- R6: An entry that is not valid never gives a hit, even when its stored key equals the requested page.
- R7: A flush clears all valid flags and returns the pointer to entry 0. After a flush every lookup misses, and the next fill goes into entry 0.
- R8: When flush and fill are asserted in the same cycle, the flush takes effect and the fill is dropped. The dropped page misses afterwards, and the next fill still lands in entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_page | input | 20 | Page number to translate |
| lk_hit | output | 1 | A valid entry matches lk_page |
| lk_frame | output | 20 | Frame of the matching entry, zero on a miss |
| fl_en | input | 1 | Write a translation this cycle |
| fl_page | input | 20 | Page number being written |
| fl_frame | input | 20 | Frame being written |
| flush | input | 1 | Invalidate all entries and reset the pointer |

## Verification
The pointer is internal, so the hardest case to bring about is seeing where it points after a wrap, a flush, or a flush that collides with a fill. The bench fills pages whose frames are computed arithmetically from the fill count. It then sweeps lookups over every page it has filled, and the pattern of hits shows which entry each fill overwrote. The bench writes the all-zero page into entries that are still invalid. This exposes a design that matches on the key without checking the valid flag.

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int ENTRIES = 4,
  parameter int PW      = 20,
  parameter int FW      = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] lk_page,
  output logic          lk_hit,
  output logic [FW-1:0] lk_frame,
  input  logic          fl_en,
  input  logic [PW-1:0] fl_page,
  input  logic [FW-1:0] fl_frame,
  input  logic          flush
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld;
  logic [PW-1:0]      key [ENTRIES];
  logic [FW-1:0]      frm [ENTRIES];
  logic [IW-1:0]      ptr;
  logic [ENTRIES-1:0] match;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_ent
      assign match[g] = vld[g] && (key[g] == lk_page);

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld[g] <= 1'b0;
          key[g] <= '0;
          frm[g] <= '0;
        end else if (flush) begin
          vld[g] <= 1'b0;
        end else if (fl_en && ptr == IW'(g)) begin
          vld[g] <= 1'b1;
          key[g] <= fl_page;
          frm[g] <= fl_frame;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || flush)
      ptr <= '0;
    else if (fl_en)
      ptr <= (ptr == IW'(ENTRIES-1)) ? '0 : ptr + 1'b1;
  end

  assign lk_hit = |match;

  always_comb begin
    lk_frame = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match[i]) lk_frame = lk_frame | frm[i];
  end
endmodule

module xlat_cache_chk #(
  parameter int ENTRIES = 4,
  parameter int PW      = 20,
  parameter int FW      = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lk_hit,
  input logic [FW-1:0] lk_frame,
  input logic          fl_en,
  input logic          flush,
  input logic [ENTRIES-1:0] vld,
  input logic [ENTRIES-1:0] match,
  input logic [$bits(xlat_cache.ptr)-1:0] ptr
);
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !lk_hit |-> lk_frame == '0); // R5
  AST_INVALID_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n) (match & ~vld) == '0); // R6
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) flush |=> (vld == '0 && ptr == '0)); // R7
  AST_FLUSH_WINS: assert property (@(posedge clk) disable iff (!rst_n) (flush && fl_en) |=> !lk_hit); // R8
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n) (fl_en && !flush && $past(rst_n)) |=> ptr != $past(ptr)); // R3
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!fl_en && !flush) |=> $stable(ptr)); // R3
  AST_RESET_EMPTY: assert property (@(posedge clk) $rose(rst_n) |-> vld == '0); // R1
endmodule

bind xlat_cache xlat_cache_chk #(.ENTRIES(ENTRIES), .PW(PW), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_hit(lk_hit), .lk_frame(lk_frame),
  .fl_en(fl_en), .flush(flush), .vld(vld), .match(match), .ptr(ptr)
);

// File: tb/xlat_cache_tb.sv
module xlat_cache_tb;
  localparam int CLK_P = 10;
  localparam int N = 4;

  logic clk = 0, rst_n = 0;
  logic [19:0] lk_page = '0, fl_page = '0, fl_frame = '0;
  logic fl_en = 0, flush = 0;
  logic lk_hit;
  logic [19:0] lk_frame;
  int tests = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  xlat_cache u_dut (.clk(clk), .rst_n(rst_n), .lk_page(lk_page), .lk_hit(lk_hit),
    .lk_frame(lk_frame), .fl_en(fl_en), .fl_page(fl_page), .fl_frame(fl_frame), .flush(flush));

  function automatic logic [19:0] pg(int k); return 20'h100 + 20'(k * 7); endfunction
  function automatic logic [19:0] fr(int k); return 20'h5000 + 20'(k * 13); endfunction

  task automatic look(input logic [19:0] p, input logic eh, input logic [19:0] ef, input string rq);
    lk_page = p;
    #1;
    tests++;
    if (lk_hit !== eh || lk_frame !== ef) begin
      fails++;
      $display("FAIL %s page=%h hit=%b frame=%h expected hit=%b frame=%h", rq, p, lk_hit, lk_frame, eh, ef);
    end
  endtask

  task automatic fill(input logic [19:0] p, input logic [19:0] f, input logic fls);
    @(negedge clk);
    fl_en = 1; fl_page = p; fl_frame = f; flush = fls;
    @(negedge clk);
    fl_en = 0; flush = 0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1; @(negedge clk); flush = 0;
  endtask

  initial begin
    #(CLK_P * 5000);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: every lookup misses after reset, page 0 included
    look(20'h0, 0, 0, "R1");
    for (int k = 0; k < 6; k++) look(pg(k), 0, 0, "R1");

    // R2/R3: fill entries in order, checking after each fill
    for (int k = 0; k < N; k++) begin
      fill(pg(k), fr(k), 0);
      for (int j = 0; j < N; j++)
        look(pg(j), j <= k, (j <= k) ? fr(j) : 20'h0, "R2");
    end
    // R6: page 0 is stored in no valid entry
    look(20'h0, 0, 0, "R6");

    // R4: wrap-around, each new fill evicts the oldest entry
    for (int k = N; k < 2*N + 1; k++) begin
      fill(pg(k), fr(k), 0);
      for (int j = 0; j <= k; j++)
        look(pg(j), j > k - N, (j > k - N) ? fr(j) : 20'h0, "R4");
    end

    // R5: the output follows the page within the same cycle
    lk_page = pg(2*N); #1;
    lk_page = pg(2*N - 1); #1;
    tests++;
    if (lk_hit !== 1 || lk_frame !== fr(2*N - 1)) begin
      fails++;
      $display("FAIL R5 hit=%b frame=%h expected 1 %h", lk_hit, lk_frame, fr(2*N - 1));
    end
    look(20'hFFFFF, 0, 0, "R5");

    // R7: flush clears everything and resets the pointer
    do_flush();
    for (int j = N; j < 2*N + 1; j++) look(pg(j), 0, 0, "R7");
    // R6: fill only entry 0; entries 1-3 still hold old keys but are invalid
    fill(20'h0, 20'hABCDE, 0);
    look(20'h0, 1, 20'hABCDE, "R7");
    look(pg(2*N), 0, 0, "R6");
    look(pg(2*N - 1), 0, 0, "R6");
    // R7: the next three fills land in entries 1-3; the fourth evicts page 0 from entry 0
    for (int k = 1; k < N; k++) fill(pg(20 + k), fr(20 + k), 0);
    look(20'h0, 1, 20'hABCDE, "R7");
    fill(pg(30), fr(30), 0);
    look(20'h0, 0, 0, "R7");
    look(pg(30), 1, fr(30), "R7");

    // R8: a flush on the same edge as a fill wins
    fill(pg(40), fr(40), 1);
    look(pg(40), 0, 0, "R8");
    look(pg(30), 0, 0, "R8");
    // R8: the pointer is at entry 0, so N+1 further fills evict the first of them
    for (int k = 0; k <= N; k++) fill(pg(50 + k), fr(50 + k), 0);
    look(pg(50), 0, 0, "R8");
    look(pg(51), 1, fr(51), "R8");
    look(pg(50 + N), 1, fr(50 + N), "R8");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule